// File: doc/BRIEF.md
# Two-Phase Second-Operand Assembly Latch

This block sits in the execute stage of a small 16-bit processor. It holds the two operands that the arithmetic unit will use. The first operand is captured directly from its register read bus in the one cycle when that bus carries it. Destination and condition reads follow straight after, so that bus does not hold the value for long. The first operand is the one the arithmetic unit may later negate.

The second operand is 16 bits wide and is built in two steps within one instruction. In the first half-cycle the whole word is loaded with one of two values: a register value from the second read bus, or a sign-extended 4-bit immediate taken from the instruction's address field. In the second half-cycle a long-form instruction may rewrite the upper 12 bits. Those bits come either from a 12-bit instruction field or from a 2-bit field that is sign-extended, which completes a sign-extended 6-bit immediate. The low nibble is left as it is. For short-form instructions the second half-cycle has no effect.

Two flag bits of the instruction word steer both multiplexers. Bit 0 selects short (0) or long (1) form. Bit 1 selects register (0) or immediate (1). The sequencer supplies separate load strobes for the first operand, the first half-cycle and the second half-cycle.

Top module: `opnd_latch`

## Requirements
- R1: A synchronous active-low reset sets both operand outputs to zero at the next rising clock edge.
- R2: When `opa_ld` is high, `opnd_a` takes `rd_a` at the next edge. When `opa_ld` is low, `opnd_a` holds its value regardless of `rd_a`.
- R3: A first-half load (`ph1_ld`) sets `opnd_b[3:0]` to `rd_b[3:0]` when `instr[1]` is 0, and to `instr[15:12]` when `instr[1]` is 1.
- R4: A first-half load sets `opnd_b[15:4]` to `rd_b[15:4]` when `instr[1]` is 0. When `instr[1]` is 1, every one of those bits becomes a copy of `instr[15]`, so a 4-bit immediate is sign-extended to 16 bits.
- R5: A second-half load (`ph2_ld`) with `instr[0]`=1 and `instr[1]`=0 sets `opnd_b[15:4]` to `instr[27:16]` and keeps `opnd_b[3:0]`.
- R6: A second-half load with `instr[0]`=1 and `instr[1]`=1 sets `opnd_b[15:4]` to `instr[17:16]`, extended upward with copies of `instr[17]`. Together with the kept low nibble this gives the 6-bit value {`instr[17:16]`, low nibble} sign-extended to 16 bits. `instr[27:18]` has no effect.
- R7: A second-half load with `instr[0]`=0 leaves `opnd_b` unchanged.
- R8: When both half-cycle loads are high in one cycle, the second-half load wins for the bits it writes. A long form gives the low nibble from the first-half mux and the upper 12 bits from the long mux. A short form gives the plain first-half result.
- R9: When neither half-cycle load is high, `opnd_b` holds its value whatever the buses and instruction do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| instr | input | 28 | Instruction word: flags in bits 1:0, address field 15:12, long field 27:16 |
| rd_a | input | 16 | Read bus carrying the first (negatable) operand |
| rd_b | input | 16 | Read bus carrying the register form of the second operand |
| opa_ld | input | 1 | Capture `rd_a` into `opnd_a` |
| ph1_ld | input | 1 | First-half-cycle load of the second operand |
| ph2_ld | input | 1 | Second-half-cycle load of the second operand |
| opnd_a | output | 16 | Latched first operand |
| opnd_b | output | 16 | Assembled, sign-extended second operand |

## Verification
Both operands are plain registers driven to the outputs, so a wrong internal value shows at `opnd_a` or `opnd_b` one clock after the load that caused it. The harder faults are in the split of the second operand. A low nibble that is rewritten by a long-form second half, a short-form second half that is not ignored, or a wrong sign-extension bit only shows up for certain flag combinations and field signs. For that reason the bench walks every combination of the two flag bits, with both positive and negative immediates, and uses buses whose low and high parts differ.

// File: rtl/opl_pkg.sv
// Package: shared definitions for the operand latch.
// Assumes: instruction flag positions are fixed by the instruction set.
package opl_pkg;

    // Flag positions inside the instruction word
    localparam int unsigned FLG_LONG = 0;
    localparam int unsigned FLG_IMM  = 1;

    // Source choices for the upper part of the second operand
    typedef enum logic [1:0] {
        HI_BUS  = 2'd0,   // register read bus, upper bits
        HI_SX4  = 2'd1,   // copies of the address-field sign bit
        HI_LFLD = 2'd2,   // long instruction field
        HI_SX2  = 2'd3    // short long-immediate, sign-extended
    } hi_sel_e;

    // Pick the first-half (short path) upper source from the immediate flag
    function automatic hi_sel_e short_sel(input logic use_imm);
        return use_imm ? HI_SX4 : HI_BUS;
    endfunction

    // Pick the second-half (long path) upper source from the immediate flag
    function automatic hi_sel_e long_sel(input logic use_imm);
        return use_imm ? HI_SX2 : HI_LFLD;
    endfunction

endpackage

// File: rtl/opl_low_mux.sv
// Module: low-nibble selector for the second operand.
// Chooses between the read bus low bits and the instruction address field.
// Assumes: purely combinational; the register sits in the parent.
module opl_low_mux #(
    parameter int unsigned NIB_W = 4
) (
    input  logic             use_imm,
    input  logic [NIB_W-1:0] bus_lo,
    input  logic [NIB_W-1:0] fld,
    output logic [NIB_W-1:0] lo
);

    // Two-way select on the immediate flag
    always_comb begin
        lo = use_imm ? fld : bus_lo;
    end

endmodule

// File: rtl/opl_high_mux.sv
// Module: four-way selector for the upper bits of the second operand.
// Produces bus bits, 4-bit-immediate sign fill, the long field, or a
// sign-extended short long-immediate, as chosen by sel.
// Assumes: LIMM_W < UP_W; combinational only.
module opl_high_mux
    import opl_pkg::*;
#(
    parameter int unsigned UP_W   = 12,
    parameter int unsigned LIMM_W = 2
) (
    input  hi_sel_e           sel,
    input  logic [UP_W-1:0]   bus_hi,
    input  logic              fld_msb,
    input  logic [UP_W-1:0]   long_fld,
    output logic [UP_W-1:0]   hi
);

    localparam int unsigned PAD_W = UP_W - LIMM_W;

    logic [LIMM_W-1:0] limm;
    logic [UP_W-1:0]   limm_sx;

    // Take the low part of the long field and sign-extend it
    always_comb begin
        limm    = long_fld[LIMM_W-1:0];
        limm_sx = {{PAD_W{limm[LIMM_W-1]}}, limm};
    end

    // Four-way source select
    always_comb begin
        unique case (sel)
            HI_BUS:  hi = bus_hi;
            HI_SX4:  hi = {UP_W{fld_msb}};
            HI_LFLD: hi = long_fld;
            HI_SX2:  hi = limm_sx;
            default: hi = bus_hi;
        endcase
    end

endmodule

// File: rtl/opnd_latch.sv
// Module: two-phase operand latch (top).
// Captures the first operand from its read bus, and builds the second
// operand over two half-cycles: the first half loads a full register value
// or a sign-extended address-field immediate, and the second half (long
// form only) rewrites the upper bits from the long instruction field.
// Assumes: the sequencer raises each strobe for one cycle while the
// matching bus or instruction word is valid; INSTR_W covers the long field.
module opnd_latch
    import opl_pkg::*;
#(
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned NIB_W   = 4,
    parameter int unsigned NIB_LO  = 12,
    parameter int unsigned LIMM_W  = 2,
    parameter int unsigned INSTR_W = 28
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] instr,
    input  logic [DATA_W-1:0]  rd_a,
    input  logic [DATA_W-1:0]  rd_b,
    input  logic               opa_ld,
    input  logic               ph1_ld,
    input  logic               ph2_ld,
    output logic [DATA_W-1:0]  opnd_a,
    output logic [DATA_W-1:0]  opnd_b
);

    localparam int unsigned UP_W    = DATA_W - NIB_W;
    localparam int unsigned NIB_HI  = NIB_LO + NIB_W - 1;
    localparam int unsigned LONG_LO = NIB_LO + NIB_W;
    localparam int unsigned LONG_HI = LONG_LO + UP_W - 1;

    logic             is_long;
    logic             use_imm;
    logic [NIB_W-1:0] fld;
    logic [UP_W-1:0]  long_fld;
    logic [NIB_W-1:0] lo_nxt;
    logic [UP_W-1:0]  hi_short;
    logic [UP_W-1:0]  hi_long;
    logic [NIB_W-1:0] b_lo;
    logic [UP_W-1:0]  b_hi;
    logic             unused_instr;

    // Split the instruction word into flags and fields
    always_comb begin
        is_long  = instr[FLG_LONG];
        use_imm  = instr[FLG_IMM];
        fld      = instr[NIB_HI:NIB_LO];
        long_fld = instr[LONG_HI:LONG_LO];
    end

    assign unused_instr = ^instr[NIB_LO-1:FLG_IMM+1];

    opl_low_mux #(.NIB_W(NIB_W)) lo_mux_i (
        .use_imm (use_imm),
        .bus_lo  (rd_b[NIB_W-1:0]),
        .fld     (fld),
        .lo      (lo_nxt)
    );

    opl_high_mux #(.UP_W(UP_W), .LIMM_W(LIMM_W)) hi_short_i (
        .sel      (short_sel(use_imm)),
        .bus_hi   (rd_b[DATA_W-1:NIB_W]),
        .fld_msb  (fld[NIB_W-1]),
        .long_fld (long_fld),
        .hi       (hi_short)
    );

    opl_high_mux #(.UP_W(UP_W), .LIMM_W(LIMM_W)) hi_long_i (
        .sel      (long_sel(use_imm)),
        .bus_hi   (rd_b[DATA_W-1:NIB_W]),
        .fld_msb  (fld[NIB_W-1]),
        .long_fld (long_fld),
        .hi       (hi_long)
    );

    // First operand: capture the read bus in its valid cycle
    always_ff @(posedge clk) begin
        if (!rst_n)      opnd_a <= '0;
        else if (opa_ld) opnd_a <= rd_a;
    end

    // Second operand low nibble: written only by the first half-cycle
    always_ff @(posedge clk) begin
        if (!rst_n)      b_lo <= '0;
        else if (ph1_ld) b_lo <= lo_nxt;
    end

    // Second operand upper bits: long second half wins over first half
    always_ff @(posedge clk) begin
        if (!rst_n)                 b_hi <= '0;
        else if (ph2_ld && is_long) b_hi <= hi_long;
        else if (ph1_ld)            b_hi <= hi_short;
    end

    assign opnd_b = {b_hi, b_lo};

endmodule

// File: rtl/opnd_latch_chk.sv
// Module: property checker for the operand latch, bound to the top.
// Assumes: default field layout (flags in bits 1:0, fields at 15:12, 27:16).
module opnd_latch_chk #(
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned INSTR_W = 28
) (
    input logic               clk,
    input logic               rst_n,
    input logic [INSTR_W-1:0] instr,
    input logic [DATA_W-1:0]  rd_a,
    input logic               opa_ld,
    input logic               ph1_ld,
    input logic               ph2_ld,
    input logic [DATA_W-1:0]  opnd_a,
    input logic [DATA_W-1:0]  opnd_b
);

    AST_A_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        opa_ld |=> opnd_a == $past(rd_a));                                // R2

    AST_A_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !opa_ld |=> $stable(opnd_a));                                     // R2

    AST_SHORT_IMM_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (ph1_ld && instr[1] && !(ph2_ld && instr[0]))
        |=> opnd_b == {{12{$past(instr[15])}}, $past(instr[15:12])});    // R4

    AST_LONG_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ph2_ld && !ph1_ld && instr[0])
        |=> opnd_b[3:0] == $past(opnd_b[3:0]));                           // R5

    AST_SHORT_PH2_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (ph2_ld && !ph1_ld && !instr[0]) |=> $stable(opnd_b));            // R7

    AST_BOTH_LONG: assert property (@(posedge clk) disable iff (!rst_n)
        (ph1_ld && ph2_ld && instr[0] && !instr[1])
        |=> opnd_b[15:4] == $past(instr[27:16]));                         // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ph1_ld && !ph2_ld) |=> $stable(opnd_b));                        // R9

endmodule

bind opnd_latch opnd_latch_chk #(.DATA_W(DATA_W), .INSTR_W(INSTR_W)) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .instr  (instr),
    .rd_a   (rd_a),
    .opa_ld (opa_ld),
    .ph1_ld (ph1_ld),
    .ph2_ld (ph2_ld),
    .opnd_a (opnd_a),
    .opnd_b (opnd_b)
);

// File: tb/opnd_latch_tb_top.sv
// Scoreboard bench: the driver applies one vector per cycle and pushes the
// expected operands; the monitor pops and compares just after each edge.
module opnd_latch_tb_top;

    typedef struct {
        logic [15:0] a;
        logic [15:0] b;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [27:0] instr = '0;
    logic [15:0] rd_a = '0;
    logic [15:0] rd_b = '0;
    logic        opa_ld = 1'b0;
    logic        ph1_ld = 1'b0;
    logic        ph2_ld = 1'b0;
    logic [15:0] opnd_a;
    logic [15:0] opnd_b;

    item_t       sb_q[$];
    logic [15:0] m_a = '0;
    logic [15:0] m_b = '0;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    opnd_latch dut_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .instr  (instr),
        .rd_a   (rd_a),
        .rd_b   (rd_b),
        .opa_ld (opa_ld),
        .ph1_ld (ph1_ld),
        .ph2_ld (ph2_ld),
        .opnd_a (opnd_a),
        .opnd_b (opnd_b)
    );

    // Build an instruction word: flags, address field, long field
    function automatic logic [27:0] mk(input logic lng, input logic imm,
                                       input logic [3:0] fld,
                                       input logic [11:0] lf);
        return {lf, fld, 10'h2A5, imm, lng};
    endfunction

    // Driver: apply one vector and push the expected result
    task automatic vec(input logic rn, input logic la, input logic [15:0] a,
                       input logic l1, input logic l2, input logic [27:0] ins,
                       input logic [15:0] b, input string tag);
        logic signed [3:0] s4;
        logic signed [5:0] s6;
        item_t it;
        @(negedge clk);
        rst_n = rn; opa_ld = la; rd_a = a; ph1_ld = l1; ph2_ld = l2;
        instr = ins; rd_b = b;
        if (!rn) begin
            m_a = '0; m_b = '0;
        end else begin
            if (la) m_a = a;
            if (l1) begin
                s4  = ins[15:12];
                m_b = ins[1] ? 16'(s4) : b;
            end
            if (l2 && ins[0]) begin
                s6  = {ins[17:16], m_b[3:0]};
                m_b = ins[1] ? 16'(s6) : {ins[27:16], m_b[3:0]};
            end
        end
        it.a = m_a; it.b = m_b; it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: compare outputs just after each rising edge
    initial begin
        forever begin
            item_t it;
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                n_chk++;
                if (opnd_a !== it.a || opnd_b !== it.b) begin
                    n_bad++;
                    $display("FAIL %s: got a=%h b=%h, expected a=%h b=%h",
                             it.tag, opnd_a, opnd_b, it.a, it.b);
                end
            end
        end
    end

    // Watchdog: a hung run counts as one failure
    initial begin
        #1000000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    // Stimulus
    initial begin
        logic [15:0] lf;
        // R1 reset clears both operands
        vec(0, 1, 16'hFFFF, 1, 1, mk(1, 0, 4'hF, 12'hFFF), 16'hFFFF, "R1 reset");
        vec(0, 0, 16'h1234, 0, 0, '0, 16'h4321, "R1 reset hold");
        // R2 first operand capture and hold
        vec(1, 1, 16'hA5C3, 0, 0, '0, '0, "R2 capture");
        vec(1, 1, 16'h0F0F, 0, 0, '0, '0, "R2 capture second");
        vec(1, 0, 16'hDEAD, 0, 0, '0, '0, "R2 hold");
        // R3/R4 first half, register form
        vec(1, 0, 16'h0000, 1, 0, mk(0, 0, 4'h9, 12'h000), 16'hBE37, "R3 R4 reg short");
        vec(1, 0, 16'h0000, 1, 0, mk(1, 0, 4'h9, 12'h000), 16'h7E18, "R3 R4 reg long ph1");
        // R3/R4 first half, immediate form, both signs
        vec(1, 0, 16'h0000, 1, 0, mk(0, 1, 4'h5, 12'hABC), 16'hFFFF, "R3 R4 imm4 pos");
        vec(1, 0, 16'h0000, 1, 0, mk(0, 1, 4'hA, 12'h123), 16'h0000, "R3 R4 imm4 neg");
        // R7 short second half leaves the operand alone
        vec(1, 0, 16'h0000, 0, 1, mk(0, 0, 4'h0, 12'h555), 16'h1111, "R7 short ph2 reg");
        vec(1, 0, 16'h0000, 0, 1, mk(0, 1, 4'h3, 12'hFFF), 16'h2222, "R7 short ph2 imm");
        // R5 long register form: upper from long field
        vec(1, 0, 16'h0000, 1, 0, mk(1, 0, 4'h0, 12'h000), 16'h3C6D, "R5 setup");
        vec(1, 0, 16'h0000, 0, 1, mk(1, 0, 4'h7, 12'h9E4), 16'h0000, "R5 long reg");
        // R6 long immediate form: 6-bit immediate, both signs
        vec(1, 0, 16'h0000, 1, 0, mk(1, 1, 4'hB, 12'h000), 16'h0000, "R6 setup neg");
        vec(1, 0, 16'h0000, 0, 1, mk(1, 1, 4'h0, 12'hFFE), 16'h0000, "R6 long imm neg");
        vec(1, 0, 16'h0000, 1, 0, mk(1, 1, 4'hC, 12'h000), 16'hFFFF, "R6 setup pos");
        vec(1, 0, 16'h0000, 0, 1, mk(1, 1, 4'h0, 12'hAA1), 16'hFFFF, "R6 long imm pos");
        // R8 both loads in one cycle, every flag combination
        vec(1, 0, 16'h0000, 1, 1, mk(1, 0, 4'h2, 12'h5A5), 16'h8E41, "R8 both long reg");
        vec(1, 0, 16'h0000, 1, 1, mk(1, 1, 4'hE, 12'h002), 16'h0000, "R8 both long imm");
        vec(1, 0, 16'h0000, 1, 1, mk(0, 0, 4'h2, 12'h5A5), 16'h6B19, "R8 both short reg");
        vec(1, 0, 16'h0000, 1, 1, mk(0, 1, 4'h8, 12'h000), 16'h0000, "R8 both short imm");
        // R9 no load: operand holds despite changing inputs
        vec(1, 0, 16'h0000, 0, 0, mk(1, 1, 4'hF, 12'hFFF), 16'hFFFF, "R9 idle");
        vec(1, 0, 16'h0000, 0, 0, mk(0, 0, 4'h0, 12'h000), 16'h0000, "R9 idle second");
        // R1 reset in the middle of a run
        vec(0, 1, 16'h7777, 1, 0, mk(0, 0, 4'h0, 12'h000), 16'h7777, "R1 reset mid");
        vec(1, 0, 16'h0000, 0, 0, '0, '0, "R1 after reset");
        // Mixed pass over all flag combinations and strobe patterns
        lf = 16'hACE1;
        for (int i = 0; i < 96; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            vec(1, lf[0], {lf[7:0], lf[15:8]}, lf[1] | lf[5], lf[2],
                mk(lf[3], lf[4], lf[11:8], {lf[5:0], lf[15:10]}),
                ~lf, "R3 R4 R5 R6 R8 mix");
        end
        vec(1, 0, 16'h0000, 0, 0, '0, '0, "R9 final hold");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule